// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, a 16-bit selector together with a 32-bit offset, into a 32-bit linear address. It looks the selector up in a small descriptor table held in local registers. Before it adds the segment base to the offset, it runs a fixed series of protection checks. When every check passes, it presents the linear address with a one-cycle valid strobe. When a check fails, it reports a general-protection fault or a not-present fault, and the error code is the offending selector.

The descriptor table is filled through a plain write port, one entry per cycle. A separate input gives the highest index that software currently considers part of the table. Each request carries the kind of access (code fetch, data read or data write) and the current privilege level. The result appears on the clock edge after the request, so a new request can be accepted on every cycle.

Top module: `seg_xlat_unit`

## Requirements
- R1: For a request that passes every check, `lin_valid` is high for exactly the one cycle after the request, and `lin_addr` equals descriptor base plus offset, taken modulo 2^32.
- R2: A selector whose index field (bits 15:3) is zero raises a general-protection fault (`fault` = 2'b01).
- R3: An index greater than `tbl_top`, or not below the number of table entries, raises a general-protection fault.
- R4: A descriptor whose present flag is 0 raises a not-present fault (`fault` = 2'b10), never a general-protection fault.
- R5: A type mismatch raises a general-protection fault. The access kinds are encoded 2'b00 fetch, 2'b01 read, 2'b10 write, and 2'b11 is reserved. A mismatch is any of these: a fetch from a data segment; a write to a code segment; a write to a data segment without the rw flag; a read from a code segment without the rw flag; or the reserved kind.
- R6: The privilege check passes only when the descriptor privilege is numerically at least the larger of `req_cpl` and the requested privilege (selector bits 1:0). A failure raises a general-protection fault.
- R7: An offset strictly greater than the descriptor limit raises a general-protection fault. An offset equal to the limit is accepted.
- R8: The checks are evaluated in the order null, table bound, present, type, privilege, offset range, and only the first failure is reported.
- R9: On any fault, `err_code` equals the request selector and `lin_addr` is 0. When no fault is reported, `err_code` is 0 and `fault` is 2'b00.
- R10: After reset, all outputs are 0 and every table entry reads as not present.
- R11: Selector bit 2 has no effect on the result.
- R12: In a cycle after one without a request, `lin_valid` is 0 and `fault` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dt_wr_en | input | 1 | Write one descriptor entry |
| dt_wr_idx | input | IDX_W | Entry written |
| dt_wr_base | input | 32 | Segment base for the written entry |
| dt_wr_limit | input | 32 | Highest valid byte offset for the entry |
| dt_wr_present | input | 1 | Present flag |
| dt_wr_dpl | input | 2 | Descriptor privilege |
| dt_wr_code | input | 1 | 1 marks a code segment, 0 a data segment |
| dt_wr_rw | input | 1 | Readable (for code) or writable (for data) |
| tbl_top | input | 13 | Highest index currently usable |
| req_valid | input | 1 | Translation request |
| req_sel | input | 16 | Selector: index in bits 15:3, bit 2 unused, requested privilege in bits 1:0 |
| req_off | input | 32 | Offset |
| req_kind | input | 2 | Access kind |
| req_cpl | input | 2 | Current privilege level |
| lin_valid | output | 1 | Linear address valid strobe |
| lin_addr | output | 32 | Linear address |
| fault | output | 2 | 00 none, 01 general protection, 10 not present |
| err_code | output | 16 | Faulting selector |

## Verification
The bench sweeps every index, including indices past `tbl_top` and past the array, across all access kinds, all current and requested privileges, both values of bit 2, and offsets of zero, exactly at the limit and one past it. A design that used >= instead of > on the limit would reject the last byte of a segment. A design that compared only against the current privilege would let a weaker selector reach a privileged segment. A design that ordered present after type would report a general-protection fault for absent code segments. One descriptor has its base near the top of the address space, so an adder that saturates or keeps a carry bit shows up as a wrong linear address.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'b00,
      ACC_READ  = 2'b01,
      ACC_WRITE = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_GP   = 2'b01,
      FLT_NP   = 2'b10
   } flt_e;

   typedef enum logic [2:0] {
      CHK_PASS,
      CHK_NULL,
      CHK_BOUND,
      CHK_ABSENT,
      CHK_TYPE,
      CHK_PRIV,
      CHK_RANGE
   } chk_e;

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] limit;
      logic        present;
      logic [1:0]  dpl;
      logic        code;
      logic        rw;
   } seg_desc_t;

   localparam int unsigned SEL_W   = 16;
   localparam int unsigned OFF_W   = 32;
   localparam int unsigned FIELD_W = 13;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
   import seg_xlat_pkg::*;
#(
   parameter int unsigned NUM_DESC = 16,
   localparam int unsigned IDX_W = $clog2(NUM_DESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  seg_desc_t        wr_desc,
   input  logic [IDX_W-1:0] rd_idx,
   output seg_desc_t        rd_desc
);

   seg_desc_t entry_q [NUM_DESC];

   for (genvar e = 0; e < NUM_DESC; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entry_q[e] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            entry_q[e] <= wr_desc;
         end
      end
   end

   assign rd_desc = entry_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlat_pkg::*;
#(
   parameter int unsigned NUM_DESC = 16
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [OFF_W-1:0]   offset,
   input  logic [1:0]         kind,
   input  logic [1:0]         cpl,
   input  logic [FIELD_W-1:0] tbl_top,
   input  seg_desc_t          desc,
   output chk_e               verdict
);

   localparam logic [FIELD_W-1:0] LAST_IDX = FIELD_W'(NUM_DESC - 1);

   logic [FIELD_W-1:0] idx;
   logic [1:0]         rpl;
   logic [1:0]         eff_priv;
   logic               null_hit;
   logic               bound_ok;
   logic               type_ok;
   logic               priv_ok;
   logic               range_ok;

   assign idx      = sel[SEL_W-1 -: FIELD_W];
   assign rpl      = sel[1:0];
   assign null_hit = (idx == '0);
   assign bound_ok = (idx <= tbl_top) && (idx <= LAST_IDX);
   assign eff_priv = (cpl > rpl) ? cpl : rpl;
   assign priv_ok  = (desc.dpl >= eff_priv);
   assign range_ok = (offset <= desc.limit);

   always_comb begin
      unique case (acc_kind_e'(kind))
         ACC_FETCH: type_ok = desc.code;
         ACC_READ:  type_ok = !desc.code || desc.rw;
         ACC_WRITE: type_ok = !desc.code && desc.rw;
         default:   type_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (null_hit)           verdict = CHK_NULL;
      else if (!bound_ok)     verdict = CHK_BOUND;
      else if (!desc.present) verdict = CHK_ABSENT;
      else if (!type_ok)      verdict = CHK_TYPE;
      else if (!priv_ok)      verdict = CHK_PRIV;
      else if (!range_ok)     verdict = CHK_RANGE;
      else                    verdict = CHK_PASS;
   end

endmodule

// File: rtl/seg_lin_add.sv
module seg_lin_add #(
   parameter int unsigned WIDTH         = 32,
   parameter bit          CARRY_SELECT  = 1'b1,
   localparam int unsigned LO_W         = WIDTH / 2,
   localparam int unsigned HI_W         = WIDTH - LO_W
) (
   input  logic [WIDTH-1:0] base,
   input  logic [WIDTH-1:0] offset,
   output logic [WIDTH-1:0] sum
);

   if (CARRY_SELECT) begin : g_csel
      logic [LO_W:0]   lo_sum;
      logic [HI_W-1:0] hi_nc;
      logic [HI_W-1:0] hi_c;
      assign lo_sum = {1'b0, base[LO_W-1:0]} + {1'b0, offset[LO_W-1:0]};
      assign hi_nc  = base[WIDTH-1:LO_W] + offset[WIDTH-1:LO_W];
      assign hi_c   = hi_nc + HI_W'(1);
      assign sum    = {lo_sum[LO_W] ? hi_c : hi_nc, lo_sum[LO_W-1:0]};
   end else begin : g_ripple
      assign sum = base + offset;
   end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
   import seg_xlat_pkg::*;
#(
   parameter int unsigned NUM_DESC     = 16,
   parameter bit          CARRY_SELECT = 1'b1,
   localparam int unsigned IDX_W       = $clog2(NUM_DESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dt_wr_en,
   input  logic [IDX_W-1:0] dt_wr_idx,
   input  logic [31:0]      dt_wr_base,
   input  logic [31:0]      dt_wr_limit,
   input  logic             dt_wr_present,
   input  logic [1:0]       dt_wr_dpl,
   input  logic             dt_wr_code,
   input  logic             dt_wr_rw,
   input  logic [12:0]      tbl_top,
   input  logic             req_valid,
   input  logic [15:0]      req_sel,
   input  logic [31:0]      req_off,
   input  logic [1:0]       req_kind,
   input  logic [1:0]       req_cpl,
   output logic             lin_valid,
   output logic [31:0]      lin_addr,
   output logic [1:0]       fault,
   output logic [15:0]      err_code
);

   if ((NUM_DESC < 2) || (NUM_DESC > 8192) || ((NUM_DESC & (NUM_DESC - 1)) != 0)) begin : g_bad_depth
      $error("seg_xlat_unit: NUM_DESC must be a power of two from 2 to 8192");
   end

   seg_desc_t        wr_desc;
   seg_desc_t        cur_desc;
   logic [IDX_W-1:0] rd_idx;
   chk_e             verdict;
   logic [31:0]      sum;

   assign wr_desc = '{base:    dt_wr_base,
                      limit:   dt_wr_limit,
                      present: dt_wr_present,
                      dpl:     dt_wr_dpl,
                      code:    dt_wr_code,
                      rw:      dt_wr_rw};

   assign rd_idx = req_sel[3 +: IDX_W];

   seg_desc_table #(.NUM_DESC(NUM_DESC)) table_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dt_wr_en),
      .wr_idx  (dt_wr_idx),
      .wr_desc (wr_desc),
      .rd_idx  (rd_idx),
      .rd_desc (cur_desc)
   );

   seg_check #(.NUM_DESC(NUM_DESC)) check_i (
      .sel     (req_sel),
      .offset  (req_off),
      .kind    (req_kind),
      .cpl     (req_cpl),
      .tbl_top (tbl_top),
      .desc    (cur_desc),
      .verdict (verdict)
   );

   seg_lin_add #(.WIDTH(32), .CARRY_SELECT(CARRY_SELECT)) add_i (
      .base   (cur_desc.base),
      .offset (req_off),
      .sum    (sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lin_valid <= 1'b0;
         lin_addr  <= '0;
         fault     <= FLT_NONE;
         err_code  <= '0;
      end else begin
         lin_valid <= 1'b0;
         lin_addr  <= '0;
         fault     <= FLT_NONE;
         err_code  <= '0;
         if (req_valid) begin
            if (verdict == CHK_PASS) begin
               lin_valid <= 1'b1;
               lin_addr  <= sum;
            end else begin
               fault    <= (verdict == CHK_ABSENT) ? FLT_NP : FLT_GP;
               err_code <= req_sel;
            end
         end
      end
   end

endmodule

// File: rtl/seg_xlat_unit_chk.sv
module seg_xlat_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [12:0] tbl_top,
   input logic        req_valid,
   input logic [15:0] req_sel,
   input logic        lin_valid,
   input logic [31:0] lin_addr,
   input logic [1:0]  fault,
   input logic [15:0] err_code
);

   a_r1_strobe_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (lin_valid || (fault != 2'b00)));

   a_r12_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_valid || (fault != 2'b00)) |-> $past(req_valid));

   a_r9_pass_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
      lin_valid |-> ((fault == 2'b00) && (err_code == 16'h0)));

   a_r9_err_is_selector: assert property (@(posedge clk) disable iff (!rst_n)
      (fault != 2'b00) |-> ((err_code == $past(req_sel)) && (lin_addr == 32'h0)));

   a_r2_null_is_gp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_sel[15:3] == 13'h0)) |=> (fault == 2'b01));

   a_r3_bound_is_gp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_sel[15:3] != 13'h0) && (req_sel[15:3] > tbl_top)) |=> (fault == 2'b01));

   a_r4_fault_encoding: assert property (@(posedge clk) disable iff (!rst_n)
      fault != 2'b11);

endmodule

bind seg_xlat_unit seg_xlat_unit_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tbl_top   (tbl_top),
   .req_valid (req_valid),
   .req_sel   (req_sel),
   .lin_valid (lin_valid),
   .lin_addr  (lin_addr),
   .fault     (fault),
   .err_code  (err_code)
);

// File: tb/seg_xlat_unit_tb_top.sv
module seg_xlat_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NDESC      = 8;
   localparam int IW         = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dt_wr_en = 1'b0;
   logic [IW-1:0] dt_wr_idx = '0;
   logic [31:0]   dt_wr_base = '0;
   logic [31:0]   dt_wr_limit = '0;
   logic          dt_wr_present = 1'b0;
   logic [1:0]    dt_wr_dpl = '0;
   logic          dt_wr_code = 1'b0;
   logic          dt_wr_rw = 1'b0;
   logic [12:0]   tbl_top = '0;
   logic          req_valid = 1'b0;
   logic [15:0]   req_sel = '0;
   logic [31:0]   req_off = '0;
   logic [1:0]    req_kind = '0;
   logic [1:0]    req_cpl = '0;
   logic          lin_valid;
   logic [31:0]   lin_addr;
   logic [1:0]    fault;
   logic [15:0]   err_code;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   logic [31:0] m_base [NDESC];
   logic [31:0] m_lim  [NDESC];
   logic        m_pres [NDESC];
   logic [1:0]  m_dpl  [NDESC];
   logic        m_code [NDESC];
   logic        m_rw   [NDESC];

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_xlat_unit #(.NUM_DESC(NDESC)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .dt_wr_en(dt_wr_en), .dt_wr_idx(dt_wr_idx), .dt_wr_base(dt_wr_base),
      .dt_wr_limit(dt_wr_limit), .dt_wr_present(dt_wr_present), .dt_wr_dpl(dt_wr_dpl),
      .dt_wr_code(dt_wr_code), .dt_wr_rw(dt_wr_rw), .tbl_top(tbl_top),
      .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
      .req_kind(req_kind), .req_cpl(req_cpl),
      .lin_valid(lin_valid), .lin_addr(lin_addr), .fault(fault), .err_code(err_code)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input int i, input logic [31:0] b, input logic [31:0] l,
                           input logic p, input logic [1:0] d, input logic c, input logic w);
      @(negedge clk);
      dt_wr_en = 1'b1; dt_wr_idx = IW'(i); dt_wr_base = b; dt_wr_limit = l;
      dt_wr_present = p; dt_wr_dpl = d; dt_wr_code = c; dt_wr_rw = w;
      m_base[i] = b; m_lim[i] = l; m_pres[i] = p; m_dpl[i] = d; m_code[i] = c; m_rw[i] = w;
      @(negedge clk);
      dt_wr_en = 1'b0;
   endtask

   // Expected result from the requirements (R2..R8 order, R1 sum)
   task automatic model(input logic [15:0] s, input logic [31:0] o, input logic [1:0] k,
                        input logic [1:0] c, output logic [1:0] ef, output logic [31:0] el);
      int  idx;
      int  mp;
      bit  bad_type;
      idx = int'(s[15:3]);
      mp  = (c > s[1:0]) ? int'(c) : int'(s[1:0]);
      ef  = 2'b00;
      el  = 32'h0;
      if (idx == 0) ef = 2'b01;
      else if (idx > int'(tbl_top) || idx >= NDESC) ef = 2'b01;
      else if (!m_pres[idx]) ef = 2'b10;
      else begin
         bad_type = (k == 2'b11) || (k == 2'b00 && !m_code[idx]) ||
                    (k == 2'b10 && (m_code[idx] || !m_rw[idx])) ||
                    (k == 2'b01 && m_code[idx] && !m_rw[idx]);
         if (bad_type) ef = 2'b01;
         else if (int'(m_dpl[idx]) < mp) ef = 2'b01;
         else if (o > m_lim[idx]) ef = 2'b01;
         else el = m_base[idx] + o;
      end
   endtask

   task automatic do_req(input logic [15:0] s, input logic [31:0] o, input logic [1:0] k,
                         input logic [1:0] c, input string tag);
      logic [1:0]  ef;
      logic [31:0] el;
      model(s, o, k, c, ef, el);
      @(negedge clk);
      req_valid = 1'b1; req_sel = s; req_off = o; req_kind = k; req_cpl = c;
      @(negedge clk);
      req_valid = 1'b0;
      check(fault == ef, {tag, " fault"}, 64'(fault), 64'(ef));
      check(lin_valid == (ef == 2'b00), {tag, " R1 lin_valid"}, 64'(lin_valid), 64'(ef == 2'b00));
      check(lin_addr == el, {tag, " R1 lin_addr"}, 64'(lin_addr), 64'(el));
      check(err_code == ((ef != 2'b00) ? s : 16'h0), {tag, " R9 err_code"}, 64'(err_code),
            64'((ef != 2'b00) ? s : 16'h0));
      @(negedge clk);
      check(!lin_valid && fault == 2'b00, "R12 idle output", 64'({lin_valid, fault}), 64'h0);
   endtask

   task automatic sweep(input logic [12:0] top);
      tbl_top = top;
      for (int i = 0; i < 10; i++)
         for (int ti = 0; ti < 2; ti++)
            for (int k = 0; k < 3; k++)
               for (int c = 0; c < 4; c++)
                  for (int r = 0; r < 4; r++)
                     for (int v = 0; v < 3; v++) begin
                        logic [31:0] off;
                        logic [15:0] s;
                        s = {13'(i), 1'(ti), 2'(r)};
                        if (i >= NDESC || v == 0) off = 32'h0;
                        else if (v == 1) off = m_lim[i];
                        else off = (m_lim[i] == 32'hFFFF_FFFF) ? 32'h0000_2000 : m_lim[i] + 32'h1;
                        do_req(s, off, 2'(k), 2'(c), "R2 R3 R4 R5 R6 R7 R8 R11 sweep");
                     end
   endtask

   initial begin
      for (int i = 0; i < NDESC; i++) begin
         m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 1'b0;
         m_dpl[i] = '0; m_code[i] = 1'b0; m_rw[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!lin_valid && fault == 2'b00 && lin_addr == 32'h0 && err_code == 16'h0,
            "R10 reset outputs", 64'({lin_valid, fault, lin_addr, err_code}), 64'h0);
      tbl_top = 13'd7;
      do_req({13'd3, 3'b000}, 32'h0, 2'b01, 2'b00, "R10 empty entry not present");
      put_desc(1, 32'h1000_0000, 32'h0000_0FFF, 1'b1, 2'd3, 1'b1, 1'b1);
      put_desc(2, 32'h2000_0000, 32'h0000_FFFF, 1'b1, 2'd3, 1'b0, 1'b1);
      put_desc(3, 32'h3000_0100, 32'h0000_7FFF, 1'b1, 2'd3, 1'b0, 1'b0);
      put_desc(4, 32'h4000_0000, 32'h0000_03FF, 1'b1, 2'd0, 1'b1, 1'b0);
      put_desc(5, 32'h5000_0000, 32'h0000_FFFF, 1'b0, 2'd0, 1'b1, 1'b0);
      put_desc(6, 32'hFFFF_F000, 32'hFFFF_FFFF, 1'b1, 2'd1, 1'b0, 1'b1);
      put_desc(7, 32'h7000_0000, 32'h0001_FFFF, 1'b1, 2'd2, 1'b1, 1'b1);
      sweep(13'd5);
      sweep(13'd12);
      tbl_top = 13'd7;
      do_req({13'd6, 3'b001}, 32'h0000_2000, 2'b10, 2'b00, "R1 wrap to 0x1000");
      check(lin_addr == 32'h0 && n_checks > 0, "R1 wrap idle", 64'(lin_addr), 64'h0);
      do_req({13'd2, 3'b000}, 32'h10, 2'b11, 2'b00, "R5 reserved kind");
      do_req({13'd5, 3'b011}, 32'h0002_0000, 2'b10, 2'b11, "R8 absent before type priv range");
      do_req({13'd4, 3'b000}, 32'h0000_0400, 2'b00, 2'b00, "R7 one past limit");
      do_req({13'd4, 3'b000}, 32'h0000_03FF, 2'b00, 2'b00, "R7 exactly at limit");
      do_req({13'd4, 3'b001}, 32'h0, 2'b00, 2'b00, "R6 rpl raises demand");
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule